// File: doc/BRIEF.md
# Signed Integer to Binary32 Converter

This block turns a two's-complement signed integer into an IEEE 754 single-precision value. It takes one operand per strobe and returns the packed float one clock later, along with a five-bit exception-flag vector. The magnitude is normalised with a leading-zero count. Bits that do not fit the 23-bit fraction are rounded under one of five modes.

The mode comes from a three-bit field that travels with the operand. One code in that field defers the choice to a separately held dynamic mode. When the field or the dynamic mode gives an unusable selection, the block flags the request as illegal instead of producing a value. In that case the result and flag outputs are left untouched, so nothing is committed.

Top module: `i2f_conv`

## Requirements
- R1: `out_valid` is high for exactly the cycle after a legal `in_valid` cycle. Synchronous reset drives `out_valid`, `out_illegal`, `out_result` and `out_flags` to zero.
- R2: An operand whose magnitude is at most 2^24 converts exactly, and its inexact flag is clear.
- R3: Rounding-field codes are: 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 nearest with ties away from zero, 111 take the mode from `dyn_rm` (same code table).
- R4: These selections are illegal: field code 101 or 110, or field code 111 while `dyn_rm` is 101, 110 or 111. In the cycle after such a request, `out_illegal` is high and `out_valid` is low, and `out_result` and `out_flags` keep their previous values.
- R5: A zero operand yields 0x00000000 with all five flags clear, under every legal mode.
- R6: `out_flags` is ordered {invalid, divide-by-zero, overflow, underflow, inexact} from bit 4 down to bit 0. Bit 0 is set exactly when the rounded value differs from the operand. Bits 4..1 are always zero.
- R7: The most negative operand, -2^31, yields 0xCF000000 with no inexact flag under every mode.
- R8: Directed rounding depends on sign. Toward minus infinity enlarges the magnitude only of inexact negative values. Toward plus infinity enlarges it only of inexact positive values.
- R9: When rounding carries out of the fraction, the exponent increases by one and the fraction becomes zero. For example, 0x7FFFFFFF under nearest-even gives 0x4F000000 with inexact set.
- R10: The result sign bit equals the operand sign bit. For a nonzero operand, the biased exponent is 127 plus the bit position of the magnitude's leading one, plus one on a rounding carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_int | input | 32 | Signed integer operand |
| in_rm | input | 3 | Rounding field of the request |
| dyn_rm | input | 3 | Dynamic rounding mode, used when `in_rm` is 111 |
| out_valid | output | 1 | Result strobe, one cycle after a legal request |
| out_result | output | 32 | Binary32 result |
| out_flags | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |
| out_illegal | output | 1 | Pulse reporting an unusable rounding selection |

## Verification
Two functions can meet in the same conversion: the rounding increment and exponent renormalisation. An increment that overflows the fraction must also bump the exponent. The bench provokes this with values just below a power of two, such as 2^k - 1 for every k above 24 and their negatives, under every mode, and compares against a model built on integer quotient and remainder arithmetic. A second collision happens when the operand and the mode selection arrive together: an illegal field with a nonzero operand must leave the previously held result intact. The bench checks this after each illegal code.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

    localparam int unsigned DEF_INT_W = 32;
    localparam int unsigned DEF_EXP_W = 8;
    localparam int unsigned DEF_MAN_W = 23;
    localparam int unsigned FLAG_W    = 5;

    // Field codes of the request's rounding selector
    localparam logic [2:0] CODE_NEAR_EVEN = 3'b000;
    localparam logic [2:0] CODE_ZERO      = 3'b001;
    localparam logic [2:0] CODE_DOWN      = 3'b010;
    localparam logic [2:0] CODE_UP        = 3'b011;
    localparam logic [2:0] CODE_NEAR_MAX  = 3'b100;
    localparam logic [2:0] CODE_DYNAMIC   = 3'b111;

    typedef enum logic [2:0] {
        RND_NEAR_EVEN = 3'd0,
        RND_ZERO      = 3'd1,
        RND_DOWN      = 3'd2,
        RND_UP        = 3'd3,
        RND_NEAR_MAX  = 3'd4
    } round_mode_e;

    // Flag vector, MSB first: invalid, div-zero, overflow, underflow, inexact
    typedef struct packed {
        logic nv;
        logic dz;
        logic of;
        logic uf;
        logic nx;
    } fflags_t;

    // Bits that the fraction cannot hold, reduced to round inputs
    typedef struct packed {
        logic lsb;
        logic guard;
        logic sticky;
    } tail_t;

    function automatic logic code_is_direct(input logic [2:0] code);
        return code <= CODE_NEAR_MAX;
    endfunction

    function automatic round_mode_e code_to_mode(input logic [2:0] code);
        return round_mode_e'(code);
    endfunction

    // Decide whether the truncated magnitude must grow by one ulp
    function automatic logic needs_increment(input round_mode_e mode,
                                             input logic        neg,
                                             input tail_t       t);
        logic lost;
        lost = t.guard | t.sticky;
        unique case (mode)
            RND_NEAR_EVEN: return t.guard & (t.sticky | t.lsb);
            RND_ZERO:      return 1'b0;
            RND_DOWN:      return neg & lost;
            RND_UP:        return ~neg & lost;
            RND_NEAR_MAX:  return t.guard;
            default:       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/i2f_rm_sel.sv
module i2f_rm_sel
    import i2f_pkg::*;
(
    input  logic [2:0]  instr_rm,
    input  logic [2:0]  dyn_rm,
    output round_mode_e mode,
    output logic        illegal
);
    logic [2:0] picked;

    always_comb begin
        picked  = (instr_rm == CODE_DYNAMIC) ? dyn_rm : instr_rm;
        illegal = 1'b0;
        if (instr_rm != CODE_DYNAMIC && !code_is_direct(instr_rm))
            illegal = 1'b1;
        if (instr_rm == CODE_DYNAMIC && !code_is_direct(dyn_rm))
            illegal = 1'b1;
        mode = illegal ? RND_NEAR_EVEN : code_to_mode(picked);
    end
endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
    parameter int unsigned W  = 32,
    localparam int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] count
);
    // Later (higher) set bits override earlier ones, so the top one wins
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < int'(W); i++) begin
            if (vec[i]) count = CW'(int'(W) - 1 - i);
        end
    end
endmodule

// File: rtl/i2f_norm.sv
module i2f_norm
    import i2f_pkg::*;
#(
    parameter int unsigned INT_W = DEF_INT_W,
    parameter int unsigned EXP_W = DEF_EXP_W,
    parameter int unsigned MAN_W = DEF_MAN_W
) (
    input  logic [INT_W-1:0] operand,
    output logic             neg,
    output logic             is_zero,
    output logic [EXP_W-1:0] exp_b,
    output logic [MAN_W-1:0] frac,
    output tail_t            tail
);
    localparam int unsigned DROP = INT_W - 1 - MAN_W;
    localparam int unsigned BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int unsigned CW   = $clog2(INT_W + 1);

    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] aligned;
    logic [CW-1:0]    lz;

    assign neg     = operand[INT_W-1];
    assign mag     = neg ? (~operand + INT_W'(1)) : operand;
    assign is_zero = (operand == '0);

    i2f_lzc #(.W(INT_W)) u_lzc (
        .vec   (mag),
        .count (lz)
    );

    assign aligned = mag << lz;
    assign exp_b   = EXP_W'(int'(BIAS) + int'(INT_W) - 1 - int'(lz));
    assign frac    = aligned[INT_W-2 -: MAN_W];

    generate
        if (DROP >= 2) begin : g_wide_tail
            assign tail = '{lsb: aligned[DROP], guard: aligned[DROP-1],
                            sticky: |aligned[DROP-2:0]};
        end else if (DROP == 1) begin : g_guard_only
            assign tail = '{lsb: aligned[1], guard: aligned[0], sticky: 1'b0};
        end else begin : g_exact
            assign tail = '{lsb: aligned[0], guard: 1'b0, sticky: 1'b0};
        end
    endgenerate
endmodule

// File: rtl/i2f_round.sv
module i2f_round
    import i2f_pkg::*;
#(
    parameter int unsigned EXP_W = DEF_EXP_W,
    parameter int unsigned MAN_W = DEF_MAN_W,
    localparam int unsigned FW   = 1 + EXP_W + MAN_W
) (
    input  round_mode_e      mode,
    input  logic             neg,
    input  logic             is_zero,
    input  logic [EXP_W-1:0] exp_b,
    input  logic [MAN_W-1:0] frac,
    input  tail_t            tail,
    output logic [FW-1:0]    packed_f,
    output fflags_t          flags
);
    logic           bump;
    logic [MAN_W:0] sum;
    logic [EXP_W-1:0] exp_r;

    always_comb begin
        bump  = needs_increment(mode, neg, tail);
        sum   = {1'b0, frac} + (MAN_W + 1)'(bump);
        exp_r = exp_b + EXP_W'(sum[MAN_W]);
        flags = '0;
        if (is_zero) begin
            packed_f = '0;
        end else begin
            packed_f = {neg, exp_r, sum[MAN_W-1:0]};
            flags.nx = tail.guard | tail.sticky;
        end
    end
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
    import i2f_pkg::*;
#(
    parameter int unsigned INT_W = DEF_INT_W,
    parameter int unsigned EXP_W = DEF_EXP_W,
    parameter int unsigned MAN_W = DEF_MAN_W,
    localparam int unsigned FW   = 1 + EXP_W + MAN_W,
    localparam int unsigned BIAS = (1 << (EXP_W - 1)) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INT_W-1:0]  in_int,
    input  logic [2:0]        in_rm,
    input  logic [2:0]        dyn_rm,
    output logic              out_valid,
    output logic [FW-1:0]     out_result,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_illegal
);
    round_mode_e      mode;
    logic             bad_rm;
    logic             neg, is_zero;
    logic [EXP_W-1:0] exp_b;
    logic [MAN_W-1:0] frac;
    tail_t            tail;
    logic [FW-1:0]    next_f;
    fflags_t          next_flags;

    i2f_rm_sel u_sel (
        .instr_rm (in_rm),
        .dyn_rm   (dyn_rm),
        .mode     (mode),
        .illegal  (bad_rm)
    );

    i2f_norm #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .operand (in_int),
        .neg     (neg),
        .is_zero (is_zero),
        .exp_b   (exp_b),
        .frac    (frac),
        .tail    (tail)
    );

    i2f_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_round (
        .mode     (mode),
        .neg      (neg),
        .is_zero  (is_zero),
        .exp_b    (exp_b),
        .frac     (frac),
        .tail     (tail),
        .packed_f (next_f),
        .flags    (next_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
            out_flags   <= '0;
        end else begin
            out_valid   <= in_valid & ~bad_rm;
            out_illegal <= in_valid & bad_rm;
            if (in_valid && !bad_rm) begin
                out_result <= next_f;
                out_flags  <= next_flags;
            end
        end
    end

    // R1: a result never appears without a request one cycle earlier
    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R4: illegal and valid are exclusive, and illegal commits nothing
    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));
    a_r4_hold_on_illegal: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> ($stable(out_result) && $stable(out_flags)));

    // R6: only the inexact position can ever be raised
    a_r6_only_nx: assert property (@(posedge clk) disable iff (rst)
        out_flags[FLAG_W-1:1] == '0);

    // R5: zero result carries no flags
    a_r5_zero_clean: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result == '0) |-> out_flags == '0);

    // R10: sign follows operand, exponent stays inside the integer range
    a_r10_sign: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_result[FW-1] == $past(in_int[INT_W-1]));
    a_r10_exp_range: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_result != '0) |->
        (int'(out_result[FW-2 -: EXP_W]) >= int'(BIAS) &&
         int'(out_result[FW-2 -: EXP_W]) <= int'(BIAS + INT_W)));
endmodule

// File: tb/i2f_conv_test.sv
module i2f_conv_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] in_int;
    logic [2:0]  in_rm;
    logic [2:0]  dyn_rm;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_flags;
    logic        out_illegal;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    i2f_conv uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_int(in_int),
        .in_rm(in_rm), .dyn_rm(dyn_rm), .out_valid(out_valid),
        .out_result(out_result), .out_flags(out_flags), .out_illegal(out_illegal)
    );

    // Reference: integer quotient/remainder rounding; returns {flags, result}
    function automatic logic [36:0] model(input logic [31:0] x, input int mode);
        longint v, mag, q, r, half;
        int p, sh;
        bit sgn, up;
        v   = longint'($signed(x));
        sgn = (v < 0);
        mag = sgn ? -v : v;
        if (mag == 0) return '0;
        p = 0;
        for (int i = 0; i < 32; i++) if (mag >= (64'sd1 <<< i)) p = i;
        if (p <= 23) begin
            q = mag <<< (23 - p);
            r = 0;
            up = 0;
        end else begin
            sh   = p - 23;
            q    = mag >>> sh;
            r    = mag - (q <<< sh);
            half = 64'sd1 <<< (sh - 1);
            case (mode)
                0: up = (r > half) || (r == half && q[0]);
                1: up = 0;
                2: up = sgn && r != 0;
                3: up = !sgn && r != 0;
                default: up = (r >= half);
            endcase
        end
        if (up) q = q + 1;
        if (q >= (64'sd1 <<< 24)) begin
            q = q >>> 1;
            p = p + 1;
        end
        return {4'b0, r != 0, sgn, 8'(p + 127), q[22:0]};
    endfunction

    task automatic issue(input logic [31:0] x, input logic [2:0] rm,
                         input logic [2:0] dr);
        @(negedge clk);
        in_int   = x;
        in_rm    = rm;
        dyn_rm   = dr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_ok(input logic [31:0] x, input logic [2:0] rm,
                             input logic [2:0] dr, input int mode,
                             input string req);
        logic [36:0] e;
        e = model(x, mode);
        issue(x, rm, dr);
        checks++;
        if (!(out_valid && !out_illegal && out_result == e[31:0] &&
              out_flags == e[36:32])) begin
            failures++;
            $display("FAIL %s x=%h rm=%0d dyn=%0d: got v=%b ill=%b res=%h fl=%b exp res=%h fl=%b",
                     req, x, rm, dr, out_valid, out_illegal, out_result,
                     out_flags, e[31:0], e[36:32]);
        end
    endtask

    task automatic expect_illegal(input logic [2:0] rm, input logic [2:0] dr);
        logic [31:0] prev_r;
        logic [4:0]  prev_f;
        expect_ok(32'h0000_0003, 3'd0, 3'd0, 0, "R4 setup");
        prev_r = out_result;
        prev_f = out_flags;
        issue(32'h7FFF_FFFF, rm, dr);
        checks++;
        if (!(out_illegal && !out_valid && out_result == prev_r &&
              out_flags == prev_f)) begin
            failures++;
            $display("FAIL R4 rm=%0d dyn=%0d: got ill=%b v=%b res=%h fl=%b exp ill=1 v=0 res=%h fl=%b",
                     rm, dr, out_illegal, out_valid, out_result, out_flags,
                     prev_r, prev_f);
        end
    endtask

    task automatic check_eq(input logic [36:0] got, input logic [36:0] exp,
                            input string req);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg;
        rst = 1'b1; in_valid = 1'b0; in_int = '0; in_rm = '0; dyn_rm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid || out_illegal || out_result != 0 || out_flags != 0) begin
            failures++;
            $display("FAIL R1 reset: got v=%b ill=%b res=%h fl=%b exp all zero",
                     out_valid, out_illegal, out_result, out_flags);
        end
        rst = 1'b0;

        // R1: strobe lasts one cycle only
        issue(32'd5, 3'd0, 3'd0);
        @(negedge clk);
        check_eq({36'b0, out_valid}, 37'd0, "R1 single-cycle valid");

        // Fixed anchors from the requirements (R7, R9, R5, R2)
        expect_ok(32'h8000_0000, 3'd0, 3'd0, 0, "R7");
        check_eq({out_flags, out_result}, {5'b0, 32'hCF00_0000}, "R7 literal");
        expect_ok(32'h7FFF_FFFF, 3'd0, 3'd0, 0, "R9");
        check_eq({out_flags, out_result}, {5'b00001, 32'h4F00_0000}, "R9 literal");
        expect_ok(32'd1, 3'd0, 3'd0, 0, "R2");
        check_eq({out_flags, out_result}, {5'b0, 32'h3F80_0000}, "R2 literal");

        for (int m = 0; m < 5; m++) begin
            // R5, R7 under every mode
            expect_ok(32'h0, 3'(m), 3'd0, m, "R5 zero");
            check_eq({out_flags, out_result}, 37'd0, "R5 zero literal");
            expect_ok(32'h8000_0000, 3'(m), 3'd0, m, "R7 min int");
            // R2, R9, R10: walk each power of two and its neighbours
            for (int k = 0; k < 31; k++) begin
                logic [31:0] b;
                b = 32'd1 << k;
                expect_ok(b,         3'(m), 3'd0, m, "R10 power");
                expect_ok(b + 1,     3'(m), 3'd0, m, "R8 above power");
                expect_ok(b - 1,     3'(m), 3'd0, m, "R9 below power");
                expect_ok(-b,        3'(m), 3'd0, m, "R10 negative power");
                expect_ok(-(b + 1),  3'(m), 3'd0, m, "R8 negative above");
                expect_ok(-(b - 1),  3'(m), 3'd0, m, "R9 negative below");
                expect_ok(b | (b >> 8) | 32'd1, 3'(m), 3'd0, m, "R6 tie region");
            end
            // R8: exact halfway ties in the dropped bits
            expect_ok(32'h0100_0001, 3'(m), 3'd0, m, "R8 tie odd-low");
            expect_ok(32'h0100_0003, 3'(m), 3'd0, m, "R8 tie odd");
            expect_ok(32'hFEFF_FFFD, 3'(m), 3'd0, m, "R8 tie negative");
            // R3: dynamic selection gives the same answer as the direct code
            expect_ok(32'h1234_5679, 3'd7, 3'(m), m, "R3 dynamic");
            expect_ok(32'hEDCB_A987, 3'd7, 3'(m), m, "R3 dynamic negative");
        end

        // R4: every reserved selection
        expect_illegal(3'd5, 3'd0);
        expect_illegal(3'd6, 3'd0);
        expect_illegal(3'd7, 3'd5);
        expect_illegal(3'd7, 3'd6);
        expect_illegal(3'd7, 3'd7);

        // R6 and R8: pseudo-random sweep over all modes
        lcg = 32'h1357_9BDF;
        for (int n = 0; n < 3000; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            expect_ok(lcg, 3'(n % 5), 3'd0, n % 5, "R6 sweep");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule